// File: doc/BRIEF.md
# Frame-Gated Clock-Crossing Write Buffer

This block takes active pixel samples from a video clock domain and hands them to a system clock domain through a small dual-clock FIFO. Samples are written only while the data-enable input is high, and only inside frames that have been admitted. A frame is admitted when the run-enable input is high at the moment vertical sync falls. A frame that starts with run-enable low is thrown away in full. If the FIFO has no room when a word is due, an overflow flag is raised and the rest of that frame is dropped. Writing picks up again at the next vertical sync falling edge.

The input bus carries two colour planes side by side. When the standard-select input says the planes arrive one after another, two consecutive samples are joined into one full-width word before they are written. The system side reads the FIFO in first-word-fall-through fashion: the head word is visible whenever the FIFO is not empty, and a read strobe pops it.

Top module: `frame_gated_xfifo`

## Requirements
- R1: After reset, rd_empty is 1 and wr_full and ovf_flag are 0. No word is written before the first vertical sync falling edge (vsync 1 then 0 on consecutive vclk edges), even if run_en is 1.
- R2: Only samples taken while den is 1 are written. With seq_sel 0, each sample's full 16-bit vdata is written as one word, and words come out in the order they went in.
- R3: run_en is sampled only at a vsync falling edge. If it is 0 there, every sample of that frame is discarded, even if run_en rises later in the frame. If it is 1 there, the frame is kept even if run_en falls later in the frame.
- R4: With pairing enabled (PAIR_EN=1) and seq_sel 1, two consecutive samples form one word. Bits [7:0] of the first sample go to bits [7:0] of the word, and bits [7:0] of the second go to bits [15:8]. Bits [15:8] of the input are ignored.
- R5: A lone sample still held when den falls at the end of a line is discarded. Pairing starts afresh on each line.
- R6: The FIFO holds 16 words. After 16 writes with no reads, wr_full is 1; after 15, it is 0. Words reach rd_data in the sclk domain in write order. rd_data shows the head word while rd_empty is 0, and rd_en pops it.
- R7: A word that is due while wr_full is 1 is not written, and it sets ovf_flag. All later samples of the same frame are dropped, even once the FIFO has room again.
- R8: ovf_flag stays set until the next vsync falling edge, which clears it. Writing then resumes, provided run_en was 1 at that edge.
- R9: rd_en while rd_empty is 1 has no effect on the FIFO contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vclk | input | 1 | Video clock |
| vrst_n | input | 1 | Asynchronous active-low reset, video domain |
| vsync | input | 1 | Vertical sync; its falling edge marks a frame start |
| den | input | 1 | Data enable; marks active samples |
| seq_sel | input | 1 | 1 = colour planes arrive one after another |
| vdata | input | 16 | Sample data, two 8-bit planes |
| run_en | input | 1 | Enable bit, sampled at the frame start |
| wr_full | output | 1 | FIFO full, video domain |
| ovf_flag | output | 1 | Sticky overflow, cleared at the next frame start |
| sclk | input | 1 | System clock |
| srst_n | input | 1 | Asynchronous active-low reset, system domain |
| rd_en | input | 1 | Pop the head word |
| rd_data | output | 16 | Head word of the FIFO |
| rd_empty | output | 1 | FIFO empty, system domain |

## Verification
The bench uses the default parameters: 8-bit planes, a 4-bit FIFO address (16 entries) and pairing enabled. This makes it cheap to sweep every line length from 1 to 16 words in whole-word mode, and lengths 1 to 9 in paired mode, so both the full boundary at 16 and the odd-length leftover case are covered. The small depth also means an overflow needs only 20 samples. That lets the bench check dropping for the rest of the frame, and recovery at the next frame start, within a few hundred cycles.

// File: rtl/fgx_pkg.sv
package fgx_pkg;
  // How incoming samples map onto FIFO words.
  typedef enum logic {
    LANE_WHOLE = 1'b0,
    LANE_PAIR  = 1'b1
  } lane_mode_e;

  // Pairing state: whether a first half is held.
  typedef enum logic {
    HALF_EMPTY = 1'b0,
    HALF_HELD  = 1'b1
  } half_state_e;
endpackage

// File: rtl/fgx_rst_sync.sv
module fgx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/fgx_gray_sync.sv
module fgx_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/fgx_packer.sv
module fgx_packer
  import fgx_pkg::*;
#(
  parameter int PLANE_W = 8,
  parameter bit PAIR_EN = 1'b1,
  localparam int WORD_W = 2 * PLANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              den,
  input  logic              seq_sel,
  input  logic [WORD_W-1:0] din,
  output logic              push_req,
  output logic [WORD_W-1:0] push_word
);
  generate
    if (PAIR_EN) begin : g_pair
      half_state_e        state_q, state_d;
      logic [PLANE_W-1:0] hold_q, hold_d;
      logic               hold_en;
      lane_mode_e         mode;

      assign mode = seq_sel ? LANE_PAIR : LANE_WHOLE;

      always_comb begin
        state_d   = state_q;
        hold_d    = hold_q;
        hold_en   = 1'b0;
        push_req  = 1'b0;
        push_word = din;
        if (!den) begin
          state_d = HALF_EMPTY;             // leftover half is dropped
        end else if (mode == LANE_PAIR) begin
          if (state_q == HALF_EMPTY) begin
            state_d = HALF_HELD;
            hold_en = 1'b1;
            hold_d  = din[PLANE_W-1:0];
          end else begin
            state_d   = HALF_EMPTY;
            push_req  = 1'b1;
            push_word = {din[PLANE_W-1:0], hold_q};
          end
        end else begin
          state_d  = HALF_EMPTY;
          push_req = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HALF_EMPTY;
        else        state_q <= state_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= '0;
        else if (hold_en) hold_q <= hold_d;
      end
    end else begin : g_whole
      assign push_req  = den;
      assign push_word = din;
    end
  endgenerate
endmodule

// File: rtl/fgx_frame_gate.sv
module fgx_frame_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  input  logic run_en,
  input  logic push_req,
  input  logic full,
  output logic do_write,
  output logic ovf
);
  logic vs_q;
  logic admit_q, admit_d;
  logic drop_q, drop_d;
  logic frame_start;

  always_comb begin
    frame_start = vs_q & ~vsync;
    admit_d     = frame_start ? run_en : admit_q;
    if (frame_start)                     drop_d = 1'b0;
    else if (push_req & admit_q & full)  drop_d = 1'b1;
    else                                 drop_d = drop_q;
    do_write = push_req & admit_q & ~drop_q & ~full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q    <= 1'b0;
      admit_q <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      vs_q <= vsync;
      if (frame_start) admit_q <= admit_d;
      drop_q <= drop_d;
    end
  end

  assign ovf = drop_q;
endmodule

// File: rtl/fgx_async_fifo.sv
module fgx_async_fifo #(
  parameter int W  = 16,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty
);
  logic [W-1:0] mem [DEPTH];

  logic [AW:0] wbin_q, wbin_d, wgray_q, wgray_d, wgray_s;
  logic [AW:0] rbin_q, rbin_d, rgray_q, rgray_d, rgray_s;
  logic        wr_ok, rd_ok;

  // Write side
  always_comb begin
    wr_ok   = push & ~full;
    wbin_d  = wbin_q + {{AW{1'b0}}, wr_ok};
    wgray_d = wbin_d ^ (wbin_d >> 1);
    full    = (wgray_q == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wbin_q[AW-1:0]] <= wdata;
  end

  // Read side
  always_comb begin
    empty   = (rgray_q == wgray_s);
    rd_ok   = pop & ~empty;
    rbin_d  = rbin_q + {{AW{1'b0}}, rd_ok};
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  assign rdata = mem[rbin_q[AW-1:0]];

  fgx_gray_sync #(.W(AW + 1)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_s)
  );

  fgx_gray_sync #(.W(AW + 1)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_s)
  );
endmodule

// File: rtl/frame_gated_xfifo.sv
module frame_gated_xfifo #(
  parameter int PLANE_W = 8,
  parameter int FIFO_AW = 4,
  parameter bit PAIR_EN = 1'b1,
  localparam int WORD_W = 2 * PLANE_W
) (
  input  logic              vclk,
  input  logic              vrst_n,
  input  logic              vsync,
  input  logic              den,
  input  logic              seq_sel,
  input  logic [WORD_W-1:0] vdata,
  input  logic              run_en,
  output logic              wr_full,
  output logic              ovf_flag,
  input  logic              sclk,
  input  logic              srst_n,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_empty
);
  logic              vrst_s, srst_s;
  logic              push_req, wr_push;
  logic [WORD_W-1:0] push_word;

  fgx_rst_sync u_vrst (.clk(vclk), .arst_n(vrst_n), .rst_n(vrst_s));
  fgx_rst_sync u_srst (.clk(sclk), .arst_n(srst_n), .rst_n(srst_s));

  fgx_packer #(.PLANE_W(PLANE_W), .PAIR_EN(PAIR_EN)) u_pack (
    .clk(vclk), .rst_n(vrst_s), .den(den), .seq_sel(seq_sel), .din(vdata),
    .push_req(push_req), .push_word(push_word)
  );

  fgx_frame_gate u_gate (
    .clk(vclk), .rst_n(vrst_s), .vsync(vsync), .run_en(run_en),
    .push_req(push_req), .full(wr_full), .do_write(wr_push), .ovf(ovf_flag)
  );

  fgx_async_fifo #(.W(WORD_W), .AW(FIFO_AW)) u_fifo (
    .wclk(vclk), .wrst_n(vrst_s), .push(wr_push), .wdata(push_word), .full(wr_full),
    .rclk(sclk), .rrst_n(srst_s), .pop(rd_en), .rdata(rd_data), .empty(rd_empty)
  );
endmodule

// File: rtl/fgx_chk.sv
module fgx_chk (
  input logic vclk,
  input logic rst_n,
  input logic vsync,
  input logic den,
  input logic run_en,
  input logic wr_push,
  input logic wr_full,
  input logic ovf_flag
);
  logic vs_prev, en_seen;

  always_ff @(posedge vclk or negedge rst_n) begin
    if (!rst_n) begin
      vs_prev <= 1'b0;
      en_seen <= 1'b0;
    end else begin
      vs_prev <= vsync;
      if (vs_prev && !vsync) en_seen <= run_en;
    end
  end

  assert_push_has_room_R7: assert property (@(posedge vclk) disable iff (!rst_n)
    wr_push |-> !wr_full);

  assert_push_needs_den_R2: assert property (@(posedge vclk) disable iff (!rst_n)
    wr_push |-> den);

  assert_push_in_admitted_frame_R3: assert property (@(posedge vclk) disable iff (!rst_n)
    wr_push |-> en_seen);

  assert_ovf_blocks_push_R7: assert property (@(posedge vclk) disable iff (!rst_n)
    ovf_flag |-> !wr_push);

  assert_ovf_sticky_R8: assert property (@(posedge vclk) disable iff (!rst_n)
    (ovf_flag && !(vs_prev && !vsync)) |=> ovf_flag);
endmodule

bind frame_gated_xfifo fgx_chk u_fgx_chk (
  .vclk(vclk), .rst_n(vrst_s), .vsync(vsync), .den(den), .run_en(run_en),
  .wr_push(wr_push), .wr_full(wr_full), .ovf_flag(ovf_flag)
);

// File: tb/frame_gated_xfifo_bench.sv
module frame_gated_xfifo_bench;
  logic        vclk = 1'b0, sclk = 1'b0;
  logic        vrst_n = 1'b0, srst_n = 1'b0;
  logic        vsync = 1'b0, den = 1'b0, seq_sel = 1'b0, run_en = 1'b0, rd_en = 1'b0;
  logic [15:0] vdata = '0;
  logic        wr_full, ovf_flag, rd_empty;
  logic [15:0] rd_data;

  int          n_checks = 0, n_fail = 0;
  bit          finished = 1'b0;
  logic [15:0] got [64];
  int          cnt;

  always #2.5 vclk = ~vclk;
  always #3.5 sclk = ~sclk;

  frame_gated_xfifo u_frame_gated_xfifo (
    .vclk(vclk), .vrst_n(vrst_n), .vsync(vsync), .den(den), .seq_sel(seq_sel),
    .vdata(vdata), .run_en(run_en), .wr_full(wr_full), .ovf_flag(ovf_flag),
    .sclk(sclk), .srst_n(srst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame_start(input logic en);
    @(negedge vclk) vsync = 1'b1; run_en = en;
    repeat (2) @(negedge vclk);
    vsync = 1'b0;
    repeat (2) @(negedge vclk);
  endtask

  task automatic send_line(input int n, input logic seq, input int tag);
    for (int k = 0; k < n; k++) begin
      @(negedge vclk);
      den = 1'b1; seq_sel = seq; vdata = {tag[7:0], k[7:0]};
    end
    @(negedge vclk) den = 1'b0;
    @(negedge vclk);
  endtask

  task automatic drain();
    cnt = 0;
    repeat (6) @(negedge sclk);
    while (!rd_empty && cnt < 64) begin
      got[cnt] = rd_data;
      cnt++;
      rd_en = 1'b1;
      @(negedge sclk);
    end
    rd_en = 1'b0;
    repeat (6) @(negedge vclk);
  endtask

  initial begin
    #150000000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #40 vrst_n = 1'b1; srst_n = 1'b1;
    repeat (4) @(negedge vclk);

    // R1 reset state
    check(rd_empty == 1'b1, "R1", rd_empty, 1);
    check(wr_full == 1'b0, "R1", wr_full, 0);
    check(ovf_flag == 1'b0, "R1", ovf_flag, 0);
    run_en = 1'b1;
    send_line(4, 1'b0, 8'h11);
    drain();
    check(cnt == 0, "R1 no frame start yet", cnt, 0);

    // R3 frame not admitted, enable rises mid-frame
    frame_start(1'b0);
    run_en = 1'b1;
    send_line(6, 1'b0, 8'h22);
    drain();
    check(cnt == 0, "R3 discarded frame", cnt, 0);

    // R3 admitted frame, enable falls mid-frame
    frame_start(1'b1);
    run_en = 1'b0;
    send_line(4, 1'b0, 8'h33);
    drain();
    check(cnt == 4, "R3 kept frame", cnt, 4);

    // R2 / R6 whole-word sweep over lengths 1..16
    for (int n = 1; n <= 16; n++) begin
      frame_start(1'b1);
      send_line(n, 1'b0, n);
      check(wr_full == (n == 16), "R6 full flag", wr_full, (n == 16));
      check(ovf_flag == 1'b0, "R6 no overflow", ovf_flag, 0);
      drain();
      check(cnt == n, "R2 word count", cnt, n);
      for (int i = 0; i < n && i < cnt; i++)
        check(got[i] == {n[7:0], i[7:0]}, "R2 word order", got[i], {n[7:0], i[7:0]});
    end

    // R4 / R5 paired sweep over lengths 1..9
    for (int n = 1; n <= 9; n++) begin
      frame_start(1'b1);
      send_line(n, 1'b1, 8'hA0);
      drain();
      check(cnt == n / 2, "R4 pair count", cnt, n / 2);
      for (int j = 0; j < n / 2 && j < cnt; j++) begin
        int lo, hi;
        lo = 2 * j; hi = 2 * j + 1;
        check(got[j] == {hi[7:0], lo[7:0]}, "R4 pair layout", got[j], {hi[7:0], lo[7:0]});
      end
    end

    // R5 leftover half does not carry into the next line
    frame_start(1'b1);
    send_line(3, 1'b1, 8'hB0);
    send_line(3, 1'b1, 8'hB1);
    drain();
    check(cnt == 2, "R5 count", cnt, 2);
    check(got[0] == 16'h0100, "R5 line one", got[0], 16'h0100);
    check(got[1] == 16'h0100, "R5 line two", got[1], 16'h0100);

    // R9 read while empty
    repeat (2) @(negedge sclk);
    rd_en = 1'b1;
    repeat (3) @(negedge sclk);
    rd_en = 1'b0;
    frame_start(1'b1);
    send_line(2, 1'b0, 8'h55);
    drain();
    check(cnt == 2, "R9 count", cnt, 2);
    check(got[0] == 16'h5500, "R9 head", got[0], 16'h5500);

    // R7 overflow
    frame_start(1'b1);
    send_line(20, 1'b0, 8'h77);
    check(wr_full == 1'b1, "R7 full", wr_full, 1);
    check(ovf_flag == 1'b1, "R7 flag", ovf_flag, 1);
    drain();
    check(cnt == 16, "R7 kept words", cnt, 16);
    for (int i = 0; i < 16 && i < cnt; i++)
      check(got[i] == {8'h77, i[7:0]}, "R7 data", got[i], {8'h77, i[7:0]});
    send_line(4, 1'b0, 8'h78);
    drain();
    check(cnt == 0, "R7 rest of frame dropped", cnt, 0);
    check(ovf_flag == 1'b1, "R8 flag held", ovf_flag, 1);

    // R8 recovery at next frame start
    frame_start(1'b1);
    check(ovf_flag == 1'b0, "R8 flag cleared", ovf_flag, 0);
    send_line(3, 1'b0, 8'h79);
    drain();
    check(cnt == 3, "R8 resumed", cnt, 3);
    check(got[2] == 16'h7902, "R8 data", got[2], 16'h7902);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule